// File: doc/BRIEF.md
# Two-Way Address Translation Unit with Same-Page Fetch Bypass

This block turns 32-bit virtual byte addresses into real byte addresses for a machine with 4 KB pages. The low twelve address bits are the offset inside a page and are never translated. The upper twenty bits form the virtual page number. A small two-way set-associative table translates that page number. The low page-number bits choose a set. The remaining page-number bits are compared against the tag stored in both ways. The real page number of the way that matches is joined to the untranslated offset. When neither way matches, the block reports a translation miss.

Instruction fetches that continue a sequential stream normally skip the table. The block keeps the last real fetch address, adds the fetch step to it, and uses the sum directly as long as the addition stays inside the page offset. When the addition carries into the page number, or when no previous real address is held, the fetch falls back to a table lookup with its own virtual address. Data accesses always go through the table. Entries are loaded through a single refill port, and a flush input empties the table.

Requests are accepted every cycle. The result appears on the response outputs one clock after the request.

Top module: `xlat_unit`

## Requirements
- R1: On a table hit, resp_paddr[11:0] equals the request's vaddr[11:0], and resp_paddr[27:12] equals the real page number stored in the matching entry.
- R2: The set is chosen by vaddr[15:12] and the tag is vaddr[31:16]. An entry whose set matches but whose tag differs does not hit.
- R3: Two entries with different tags in the same set are both held and both hit.
- R4: When no valid way matches, resp_miss is 1, resp_bypass is 0 and resp_paddr is 0.
- R5: A data access (req_fetch=0) always uses the table and returns resp_bypass=0, even when a sequential stream is active.
- R6: A fetch with req_fetch=1 and req_seq=1, made while a previous real address is held and where prev[11:0]+req_step is at most 0xFFF, returns prev+req_step with resp_bypass=1. It ignores req_vaddr.
- R7: A sequential fetch whose step carries past offset 0xFFF is translated through the table using its req_vaddr.
- R8: The previous real address is loaded by every fetch that yields an address, whether bypassed or hit. A fetch that misses clears it, and so do a refill and a flush. Data accesses leave it unchanged.
- R9: Each set keeps one replacement bit. A hit in way w sets it to the other way, and a refill into way w does the same. A refill of a tag that is not present goes into the way the bit names.
- R10: A refill whose tag already sits in a valid way of its set overwrites that way, so at most one way ever matches.
- R11: A flush invalidates every entry, clears every replacement bit and drops the previous real address. A refill in the same cycle as a flush is discarded.
- R12: resp_valid is 1 exactly one cycle after a cycle with req_valid=1 and 0 otherwise. A request in the same cycle as a refill or a flush sees the table contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request this cycle |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_seq | input | 1 | Fetch continues the previous fetch stream |
| req_vaddr | input | 32 | Virtual byte address |
| req_step | input | 4 | Byte increment from the previous fetch |
| fill_en | input | 1 | Write one table entry |
| fill_vpn | input | 20 | Virtual page number of the entry |
| fill_ppn | input | 16 | Real page number of the entry |
| flush | input | 1 | Invalidate the whole table |
| resp_valid | output | 1 | Response present |
| resp_paddr | output | 28 | Real byte address |
| resp_miss | output | 1 | Not found in the table |
| resp_bypass | output | 1 | Address came from the sequential increment |

## Verification
The hardest case to reach from the ports is a sequential fetch whose previous real address lies a few bytes below a page end. Then the step decides between the increment path and a lookup, and whether a held address exists depends on the whole earlier history of refills, misses and data accesses. The stimulus opens fetch streams at offsets of 0xFF0 and above and supplies deliberately wrong virtual addresses on sequential fetches, so a wrongly taken path shows up in the returned address. A random phase then mixes such streams with data accesses, refills and flushes over a small pool of colliding page numbers. A behavioural model compares every response on every clock.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef logic way_t;

  function automatic way_t flip_way(input way_t w);
    return ~w;
  endfunction

endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 16,
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             flush,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn
);

  localparam int WAYS  = 2;
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = VPN_W - SET_W;

  logic [SET_W-1:0] l_set, f_set;
  logic [TAG_W-1:0] l_tag, f_tag;
  logic [WAYS-1:0]  way_hit;
  logic [WAYS-1:0]  fill_match;
  logic [WAYS-1:0]  way_any;
  logic [PPN_W-1:0] way_ppn [WAYS];
  logic [SETS-1:0]  lru_q;
  way_t             hit_way;
  way_t             fill_way;

  function automatic logic [SET_W-1:0] set_of(input logic [VPN_W-1:0] vpn);
    return vpn[SET_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [VPN_W-1:0] vpn);
    return vpn[VPN_W-1:SET_W];
  endfunction

  assign l_set = set_of(lk_vpn);
  assign l_tag = tag_of(lk_vpn);
  assign f_set = set_of(fill_vpn);
  assign f_tag = tag_of(fill_vpn);

  // An existing copy of the tag wins over the replacement bit
  always_comb begin
    if (fill_match[0])      fill_way = 1'b0;
    else if (fill_match[1]) fill_way = 1'b1;
    else                    fill_way = lru_q[f_set];
  end

  genvar w;
  for (w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic [PPN_W-1:0] ppn_q [SETS];
    logic             wr_here;

    assign wr_here = fill_en && !flush && (fill_way == way_t'(w));

    always_ff @(posedge clk) begin
      if (!rst_n)       vld_q <= '0;
      else if (flush)   vld_q <= '0;
      else if (wr_here) vld_q[f_set] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        tag_q[f_set] <= f_tag;
        ppn_q[f_set] <= fill_ppn;
      end
    end

    assign way_hit[w]    = vld_q[l_set] && (tag_q[l_set] == l_tag);
    assign fill_match[w] = vld_q[f_set] && (tag_q[f_set] == f_tag);
    assign way_ppn[w]    = ppn_q[l_set];
    assign way_any[w]    = |vld_q;
  end

  assign lk_hit  = |way_hit;
  assign hit_way = way_hit[1];
  assign lk_ppn  = way_hit[1] ? way_ppn[1] : way_ppn[0];

  // Replacement bit names the next victim; refill update lands last
  always_ff @(posedge clk) begin
    if (!rst_n) lru_q <= '0;
    else if (flush) lru_q <= '0;
    else begin
      if (lk_en && lk_hit) lru_q[l_set] <= flip_way(hit_way);
      if (fill_en)         lru_q[f_set] <= flip_way(fill_way);
    end
  end

  // R10: no duplicate entries, so never two matching ways
  p_single_way_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  // R11: table is empty after a flush
  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (way_any == '0));

  // R9: refill leaves its set's victim pointing away from the written way
  p_fill_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> lru_q[$past(f_set)] == flip_way($past(fill_way)));

endmodule

// File: rtl/xlat_seq.sv
module xlat_seq #(
  parameter int PA_W   = 28,
  parameter int OFF_W  = 12,
  parameter int STEP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_go,
  input  logic            seq,
  input  logic [STEP_W-1:0] step,
  input  logic            tlb_hit,
  input  logic [PA_W-1:0] tlb_paddr,
  input  logic            kill,
  output logic            use_bypass,
  output logic [PA_W-1:0] byp_paddr
);

  localparam int PG_W = PA_W - OFF_W;

  logic            prev_v;
  logic [PA_W-1:0] prev_q;
  logic [OFF_W:0]  adv;

  // Offset advance with carry-out in the top bit
  function automatic logic [OFF_W:0] page_advance(
    input logic [OFF_W-1:0] off, input logic [STEP_W-1:0] inc);
    return {1'b0, off} + {{(OFF_W + 1 - STEP_W){1'b0}}, inc};
  endfunction

  assign adv        = page_advance(prev_q[OFF_W-1:0], step);
  assign use_bypass = fetch_go && seq && prev_v && !adv[OFF_W];
  assign byp_paddr  = {prev_q[PA_W-1:OFF_W], adv[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_v <= 1'b0;
      prev_q <= '0;
    end else if (kill) begin
      prev_v <= 1'b0;
    end else if (fetch_go) begin
      if (use_bypass) begin
        prev_q <= byp_paddr;
        prev_v <= 1'b1;
      end else if (tlb_hit) begin
        prev_q <= tlb_paddr;
        prev_v <= 1'b1;
      end else begin
        prev_v <= 1'b0;
      end
    end
  end

  logic [PG_W-1:0] prev_page;
  assign prev_page = prev_q[PA_W-1:OFF_W];

  // R8: refill or flush drops the held address
  p_kill_prev_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !prev_v);

  // R6: a bypassed fetch stays on the same real page
  p_bypass_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (use_bypass && !kill) |=> (prev_v && prev_page == $past(prev_page)));

endmodule

// File: rtl/xlat_unit.sv
module xlat_unit #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 28,
  parameter int OFF_W  = 12,
  parameter int SET_W  = 4,
  parameter int STEP_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_fetch,
  input  logic                    req_seq,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic [STEP_W-1:0]       req_step,
  input  logic                    fill_en,
  input  logic [VA_W-OFF_W-1:0]   fill_vpn,
  input  logic [PA_W-OFF_W-1:0]   fill_ppn,
  input  logic                    flush,
  output logic                    resp_valid,
  output logic [PA_W-1:0]         resp_paddr,
  output logic                    resp_miss,
  output logic                    resp_bypass
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic             fetch_go;
  logic             use_bypass;
  logic [PA_W-1:0]  byp_paddr;
  logic             lk_en;
  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  logic [PA_W-1:0]  tlb_paddr;

  assign fetch_go  = req_valid && req_fetch;
  assign lk_en     = req_valid && !use_bypass;
  assign tlb_paddr = {lk_ppn, req_vaddr[OFF_W-1:0]};

  xlat_tlb #(
    .VPN_W(VPN_W),
    .PPN_W(PPN_W),
    .SET_W(SET_W)
  ) u_tlb (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_en   (lk_en),
    .lk_vpn  (req_vaddr[VA_W-1:OFF_W]),
    .fill_en (fill_en),
    .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn),
    .flush   (flush),
    .lk_hit  (lk_hit),
    .lk_ppn  (lk_ppn)
  );

  xlat_seq #(
    .PA_W  (PA_W),
    .OFF_W (OFF_W),
    .STEP_W(STEP_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_go  (fetch_go),
    .seq       (req_seq),
    .step      (req_step),
    .tlb_hit   (lk_hit),
    .tlb_paddr (tlb_paddr),
    .kill      (fill_en || flush),
    .use_bypass(use_bypass),
    .byp_paddr (byp_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_paddr  <= '0;
      resp_miss   <= 1'b0;
      resp_bypass <= 1'b0;
    end else begin
      resp_valid  <= req_valid;
      resp_bypass <= req_valid && use_bypass;
      resp_miss   <= lk_en && !lk_hit;
      if (!req_valid)      resp_paddr <= '0;
      else if (use_bypass) resp_paddr <= byp_paddr;
      else if (lk_hit)     resp_paddr <= tlb_paddr;
      else                 resp_paddr <= '0;
    end
  end

  // R12: one-cycle response
  p_resp_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  p_resp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!resp_valid && !resp_miss && !resp_bypass));

  // R5: data accesses never take the increment path
  p_data_lookup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_fetch) |=> !resp_bypass);

  // R1: offset passes through on a table translation
  p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !use_bypass) |=>
      (resp_miss || resp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  // R4: a miss carries no address
  p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_miss |-> (resp_paddr == '0 && !resp_bypass));

endmodule

// File: tb/xlat_unit_bench.sv
module xlat_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_fetch = 1'b0;
  logic        req_seq = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [3:0]  req_step = '0;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [15:0] fill_ppn = '0;
  logic        flush = 1'b0;
  logic        resp_valid;
  logic [27:0] resp_paddr;
  logic        resp_miss;
  logic        resp_bypass;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_unit u_xlat_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_fetch(req_fetch), .req_seq(req_seq),
    .req_vaddr(req_vaddr), .req_step(req_step),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .flush(flush),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_miss(resp_miss), .resp_bypass(resp_bypass)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference state: entry index = set*2 + way
  bit          m_vld [32];
  int unsigned m_tag [32];
  int unsigned m_ppn [32];
  int          m_vict [16];
  bit          m_pv;
  int unsigned m_prev;

  bit          e_valid, e_miss, e_byp;
  int unsigned e_pa;

  task automatic check(input string req, input string what,
                       input int unsigned act, input int unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 32; i++) m_vld[i] = 0;
    for (int i = 0; i < 16; i++) m_vict[i] = 0;
    m_pv = 0;
  endtask

  // One cycle: drive at falling edge, predict, compare at next falling edge
  task automatic step(input bit v, input bit f, input bit s,
                      input int unsigned va, input int unsigned st,
                      input bit fe, input int unsigned fv, input int unsigned fp,
                      input bit fl, input string req);
    int    set;
    int    hitw;
    int    fset;
    int    fw;
    req_valid = v; req_fetch = f; req_seq = s; req_vaddr = va; req_step = st[3:0];
    fill_en = fe; fill_vpn = fv[19:0]; fill_ppn = fp[15:0]; flush = fl;
    e_valid = v; e_miss = 0; e_byp = 0; e_pa = 0; hitw = -1;
    if (v) begin
      if (f && s && m_pv && ((m_prev % 4096) + st) < 4096) begin
        e_byp = 1;
        e_pa = m_prev + st;
      end else begin
        set = (va >> 12) % 16;
        for (int k = 0; k < 2; k++)
          if (hitw < 0 && m_vld[set*2+k] && m_tag[set*2+k] == (va >> 16)) hitw = k;
        if (hitw >= 0) begin
          e_pa = (m_ppn[set*2+hitw] << 12) | (va % 4096);
          m_vict[set] = 1 - hitw;
        end else e_miss = 1;
      end
      if (f) begin
        if (e_byp || hitw >= 0) begin m_pv = 1; m_prev = e_pa; end
        else m_pv = 0;
      end
    end
    if (fl) model_clear();
    else if (fe) begin
      fset = fv % 16;
      fw = m_vict[fset];
      for (int k = 1; k >= 0; k--)
        if (m_vld[fset*2+k] && m_tag[fset*2+k] == (fv >> 4)) fw = k;
      m_vld[fset*2+fw] = 1;
      m_tag[fset*2+fw] = fv >> 4;
      m_ppn[fset*2+fw] = fp;
      m_vict[fset] = 1 - fw;
      m_pv = 0;
    end
    @(negedge clk);
    check(req, "resp_valid", resp_valid, e_valid);
    check(req, "resp_bypass", resp_bypass, e_byp);
    check(req, "resp_miss", resp_miss, e_miss);
    check(req, "resp_paddr", resp_paddr, e_pa);
  endtask

  task automatic lookup(input bit f, input bit s, input int unsigned va,
                        input int unsigned st, input string req);
    step(1, f, s, va, st, 0, 0, 0, 0, req);
  endtask

  task automatic refill(input int unsigned fv, input int unsigned fp, input string req);
    step(0, 0, 0, 0, 0, 1, fv, fp, 0, req);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check("R12", "resp_valid in reset", resp_valid, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");

    // Empty table misses
    lookup(0, 0, 32'h1234_5678, 0, "R4");
    // Fill and translate, offset passthrough
    refill(20'h12345, 16'hABCD, "R1");
    lookup(0, 0, 32'h1234_5678, 0, "R1");
    // Same set, other tag
    lookup(0, 0, 32'h5432_5010, 0, "R2");
    refill(20'h54325, 16'h1111, "R3");
    lookup(0, 0, 32'h5432_5010, 0, "R3");
    lookup(0, 0, 32'h1234_5ABC, 0, "R3");
    // Replacement order: touch first, third fill evicts the second
    lookup(0, 0, 32'h1234_5000, 0, "R9");
    refill(20'h77775, 16'h2222, "R9");
    lookup(0, 0, 32'h5432_5000, 0, "R9");
    lookup(0, 0, 32'h1234_5004, 0, "R9");
    lookup(0, 0, 32'h7777_5FFF, 0, "R9");

    // Sequential stream near the page end; vaddr deliberately wrong
    lookup(1, 0, 32'h1234_5FF0, 0, "R8");
    lookup(1, 1, 32'h0000_0000, 4, "R6");
    lookup(0, 0, 32'h7777_5100, 0, "R5");
    lookup(1, 1, 32'hDEAD_B000, 8, "R6");
    lookup(0, 1, 32'h1234_5000, 0, "R5");
    lookup(1, 1, 32'h1234_6000, 4, "R7");
    lookup(1, 1, 32'h1234_5004, 4, "R8");
    lookup(1, 1, 32'h1234_5008, 4, "R6");
    // Carry that hits in the table
    lookup(1, 0, 32'h7777_5FFE, 0, "R8");
    lookup(1, 1, 32'h1234_5010, 2, "R7");
    lookup(1, 1, 32'h0, 15, "R6");
    // Refill drops the held address
    refill(20'h0000A, 16'h0001, "R8");
    lookup(1, 1, 32'h1234_5020, 1, "R8");
    // Refill of a present tag rewrites that way
    refill(20'h0000A, 16'h0002, "R10");
    refill(20'h1000A, 16'h0003, "R10");
    lookup(0, 0, 32'h0000_A123, 0, "R10");
    lookup(0, 0, 32'h1000_A456, 0, "R10");
    // Request alongside refill sees old contents
    step(1, 0, 0, 32'h2000_A000, 0, 1, 20'h2000A, 16'h0004, 0, "R12");
    lookup(0, 0, 32'h2000_A000, 0, "R12");
    // Flush with a stream active; refill in the same cycle is dropped
    lookup(1, 0, 32'h1234_5100, 0, "R11");
    step(0, 0, 0, 0, 0, 1, 20'h33333, 16'h0005, 1, "R11");
    lookup(1, 1, 32'h1234_5104, 4, "R11");
    lookup(0, 0, 32'h3333_3000, 0, "R11");
    lookup(0, 0, 32'h0000_A000, 0, "R11");

    // Random mix over a small colliding pool
    for (int n = 0; n < 3000; n++) begin
      int unsigned pick  = $urandom_range(0, 99);
      int unsigned vpn   = {$urandom_range(0, 3), 12'h000, $urandom_range(0, 1) ? 4'h3 : 4'h9};
      int unsigned off   = $urandom_range(0, 1) ? $urandom_range(0, 4095) : $urandom_range(4080, 4095);
      int unsigned va    = (vpn << 12) | off;
      if (pick < 10)      refill(vpn, $urandom_range(0, 65535), "R9");
      else if (pick < 11) step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R11");
      else if (pick < 30) lookup(0, 0, va, 0, "R5");
      else if (pick < 45) lookup(1, 0, va, 0, "R8");
      else if (pick < 85) lookup(1, 1, va, $urandom_range(0, 15), "R6");
      else                step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R12 watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule